// File: doc/BRIEF.md
# Serial Transmitter with Holding Buffer, Preamble and Break

This block is the transmit half of an asynchronous serial port. A register interface writes a character into a one-entry holding buffer. At the next character boundary the character moves into a shift register. The shift register then drives the serial line one bit per `bitTick` pulse: a low start bit, the data bits least significant first, and a high stop bit. Baud-rate generation sits outside the block, so `bitTick` pulses once per bit period.

The block reports two separate conditions. `bufEmpty` means software may write the next character. `txIdle` means the line has gone quiet with nothing left to send. The block can also send two special characters besides data. A preamble is a full character time of high line; it is queued whenever `txEnable` rises. A break is held low for one character time plus one bit time; it is queued by a pulse on `sendBreak`.

`nineBit` selects the frame size, and its value is taken when each data character is loaded into the shift register:
- `nineBit`=0: 8 data bits and a 10-bit character time.
- `nineBit`=1: 9 data bits and an 11-bit character time.

Top module: `sertx_top`

## Requirements
- R1: After reset `txLine`=1, `bufEmpty`=1 and `txIdle`=1.
- R2: A cycle with `wrValid`=1 stores `wrData` and drives `bufEmpty` low from the next cycle. `bufEmpty` returns high in the cycle after the `bitTick` at which the buffered character moves into the shifter.
- R3: With `nineBit`=0 a data character is sent as ten bits, each lasting from one `bitTick` to the next: start=0, then `wrData[0]` through `wrData[7]`, then stop=1. The line changes in the cycle after each `bitTick`.
- R4: With `nineBit`=1 a data character is sent as eleven bits: start=0, then `wrData[0]` through `wrData[8]`, then stop=1.
- R5: `txIdle` is low while any character is being sent or is pending, counting buffered data, a queued preamble and a queued break. It goes high in the cycle after the `bitTick` that ends the last bit when nothing else is pending.
- R6: A 0-to-1 change of `txEnable` queues a preamble. The preamble holds the line high for 10 bit times (`nineBit`=0) or 11 bit times (`nineBit`=1), and `txIdle` is low from the cycle after the change until the preamble ends.
- R7: A `sendBreak` pulse while enabled queues a break. The break holds the line low for 11 bit times (`nineBit`=0) or 12 bit times (`nineBit`=1), after which the line returns high.
- R8: At a character boundary a queued break is sent first, then a queued preamble, then buffered data. There is no idle gap between them.
- R9: While `txEnable`=0 the line is high from the next cycle on, any character in progress is abandoned, queued preamble and break are dropped, and `sendBreak` is ignored. A write is still stored in the buffer.
- R10: A character written while the previous one is being shifted starts right after that character's stop bit, with no idle bit between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle pulse per bit period |
| txEnable | input | 1 | Transmitter enable; a rising edge queues a preamble |
| nineBit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wrValid | input | 1 | Write strobe for the holding buffer |
| wrData | input | DATA_BITS | Character to send |
| sendBreak | input | 1 | One-cycle request to queue a break |
| txLine | output | 1 | Serial output, idles high |
| bufEmpty | output | 1 | Holding buffer can accept a character |
| txIdle | output | 1 | Nothing being sent and nothing pending |

## Verification
Most internal faults reach `txLine` within one bit period. A wrong remaining-bit count shows up as a frame that is too short or too long, so the stop bit or the next start bit falls on the wrong tick. A wrong priority or a lost queued request changes the order of the low and high stretches seen after a boundary. A stale buffer-full state shows up as `bufEmpty` failing to rise in the cycle after the loading tick. It can also show up as `txIdle` staying low one bit time past the stop bit.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  // Strobes issued by the control unit to the datapath; at most one is set.
  typedef struct packed {
    logic loadData;
    logic loadPreamble;
    logic loadBreak;
    logic shift;
    logic clear;
  } txStrobe_t;
endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DATA_BITS = 9,
  localparam int ShW  = DATA_BITS + 3,
  localparam int CntW = $clog2(ShW + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitTick,
  input  logic      txEnable,
  input  logic      nineBit,
  input  logic      wrValid,
  input  logic      sendBreak,
  output txStrobe_t strb,
  output logic      bufEmpty,
  output logic      txIdle
);
  localparam logic [CntW-1:0] FrameShort = CntW'(DATA_BITS + 1);
  localparam logic [CntW-1:0] FrameLong  = CntW'(DATA_BITS + 2);

  logic            enPrev;
  logic            preamblePend;
  logic            breakPend;
  logic            bufFull;
  logic [CntW-1:0] remCnt;
  logic [CntW-1:0] frameLen;
  logic            atBoundary;

  assign frameLen   = nineBit ? FrameLong : FrameShort;
  assign atBoundary = (remCnt <= CntW'(1));

  always_comb begin
    strb = '0;
    if (!txEnable) begin
      strb.clear = 1'b1;
    end else if (bitTick) begin
      if (!atBoundary)       strb.shift        = 1'b1;
      else if (breakPend)    strb.loadBreak    = 1'b1;
      else if (preamblePend) strb.loadPreamble = 1'b1;
      else if (bufFull)      strb.loadData     = 1'b1;
      else                   strb.clear        = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev       <= 1'b0;
      preamblePend <= 1'b0;
      breakPend    <= 1'b0;
      bufFull      <= 1'b0;
      remCnt       <= '0;
    end else begin
      enPrev <= txEnable;

      if (!txEnable)              preamblePend <= 1'b0;
      else if (!enPrev)           preamblePend <= 1'b1;
      else if (strb.loadPreamble) preamblePend <= 1'b0;

      if (!txEnable)              breakPend <= 1'b0;
      else if (sendBreak)         breakPend <= 1'b1;
      else if (strb.loadBreak)    breakPend <= 1'b0;

      if (wrValid)                bufFull <= 1'b1;
      else if (strb.loadData)     bufFull <= 1'b0;

      if (strb.clear)             remCnt <= '0;
      else if (strb.loadBreak)    remCnt <= frameLen + CntW'(1);
      else if (strb.loadPreamble || strb.loadData) remCnt <= frameLen;
      else if (strb.shift)        remCnt <= remCnt - CntW'(1);
    end
  end

  assign bufEmpty = !bufFull;
  assign txIdle   = !bufFull && (remCnt == '0) && !breakPend && !preamblePend;

  // R2
  buf_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadData && !wrValid) |=> bufEmpty);
  // R2
  wr_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !bufEmpty);
  // R9
  rem_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (remCnt == '0) && !breakPend);
  // R7
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    remCnt <= CntW'(DATA_BITS + 3));
endmodule

// File: rtl/sertx_dpath.sv
module sertx_dpath
  import sertx_pkg::*;
#(
  parameter int DATA_BITS = 9,
  localparam int ShW = DATA_BITS + 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txStrobe_t            strb,
  input  logic                 wrValid,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic                 nineBit,
  output logic                 txLine
);
  logic [DATA_BITS-1:0] bufData;
  logic [ShW-1:0]       shReg;
  logic [ShW-1:0]       dataFrame;

  // Frame image, start bit in bit 0, padded above the stop bit with ones.
  assign dataFrame = nineBit ? {1'b1, 1'b1, bufData, 1'b0}
                             : {3'b111, bufData[DATA_BITS-2:0], 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) bufData <= '0;
    else if (wrValid) bufData <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  shReg <= '1;
    else if (strb.clear)        shReg <= '1;
    else if (strb.loadBreak)    shReg <= '0;
    else if (strb.loadPreamble) shReg <= '1;
    else if (strb.loadData)     shReg <= dataFrame;
    else if (strb.shift)        shReg <= {1'b1, shReg[ShW-1:1]};
  end

  assign txLine = shReg[0];

  // R8
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadData, strb.loadPreamble, strb.loadBreak, strb.shift, strb.clear}));
  // R3
  start_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadData |=> !txLine);
  // R7
  break_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadBreak |=> !txLine);
  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> txLine);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitTick,
  input  logic                 txEnable,
  input  logic                 nineBit,
  input  logic                 wrValid,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic                 sendBreak,
  output logic                 txLine,
  output logic                 bufEmpty,
  output logic                 txIdle
);
  txStrobe_t strb;

  sertx_ctrl #(.DATA_BITS(DATA_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .txEnable(txEnable),
    .nineBit(nineBit), .wrValid(wrValid), .sendBreak(sendBreak),
    .strb(strb), .bufEmpty(bufEmpty), .txIdle(txIdle)
  );

  sertx_dpath #(.DATA_BITS(DATA_BITS)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrValid(wrValid),
    .wrData(wrData), .nineBit(nineBit), .txLine(txLine)
  );

  // R5
  idle_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txIdle && txEnable) |-> txLine);
endmodule

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
  localparam int DATA_BITS = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic txEnable = 1'b0;
  logic nineBit = 1'b0;
  logic wrValid = 1'b0;
  logic [DATA_BITS-1:0] wrData = '0;
  logic sendBreak = 1'b0;
  logic txLine, bufEmpty, txIdle;

  int errors = 0;
  int checks = 0;
  int tickCnt = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tickCnt = (tickCnt == 3) ? 0 : tickCnt + 1;
    bitTick = (tickCnt == 3);
  end

  sertx_top #(.DATA_BITS(DATA_BITS)) dut_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .txEnable(txEnable),
    .nineBit(nineBit), .wrValid(wrValid), .wrData(wrData),
    .sendBreak(sendBreak), .txLine(txLine), .bufEmpty(bufEmpty), .txIdle(txIdle)
  );

  // Stimulus table: {nineBit, data}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 9'h0A5}, {1'b0, 9'h0FF}, {1'b0, 9'h001},
    {1'b1, 9'h1A5}, {1'b1, 9'h100}, {1'b1, 9'h0FE}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Return at the negedge after the next posedge that sees bitTick.
  task automatic nextBit();
    do @(posedge clk); while (!bitTick);
    @(negedge clk);
  endtask

  task automatic writeChar(input logic [DATA_BITS-1:0] d);
    wrData  = d;
    wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic pulseBreak();
    sendBreak = 1'b1;
    @(negedge clk);
    sendBreak = 1'b0;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 40 && !txIdle; k++) nextBit();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DATA_BITS-1:0] d;
    int n;
    logic [19:0] seq;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 line", txLine, 1'b1);
    check("R1 bufEmpty", bufEmpty, 1'b1);
    check("R1 txIdle", txIdle, 1'b1);

    // R6 preamble on enable rise
    txEnable = 1'b1;
    @(negedge clk);
    check("R6 idle low after enable", txIdle, 1'b0);
    for (int i = 0; i < 10; i++) begin
      nextBit();
      check("R6 preamble high", txLine, 1'b1);
      check("R6 busy during preamble", txIdle, 1'b0);
    end
    nextBit();
    check("R6 preamble ends", txIdle, 1'b1);

    // R3/R4 table walk
    for (int v = 0; v < 6; v++) begin
      nineBit = VEC[v][9];
      d = VEC[v][8:0];
      n = nineBit ? 9 : 8;
      writeChar(d);
      check("R2 buffer full after write", bufEmpty, 1'b0);
      nextBit();
      check(nineBit ? "R4 start" : "R3 start", txLine, 1'b0);
      check("R2 buffer empty after load", bufEmpty, 1'b1);
      for (int b = 0; b < n; b++) begin
        nextBit();
        check(nineBit ? "R4 data" : "R3 data", txLine, d[b]);
      end
      nextBit();
      check(nineBit ? "R4 stop" : "R3 stop", txLine, 1'b1);
      check("R5 busy in stop bit", txIdle, 1'b0);
      nextBit();
      check("R5 idle after stop", txIdle, 1'b1);
    end

    // R7 break in both modes
    for (int m = 0; m < 2; m++) begin
      nineBit = m[0];
      pulseBreak();
      for (int i = 0; i < 11 + m; i++) begin
        nextBit();
        check("R7 break low", txLine, 1'b0);
      end
      nextBit();
      check("R7 line returns high", txLine, 1'b1);
      check("R7 idle after break", txIdle, 1'b1);
    end

    // R10 back-to-back characters
    nineBit = 1'b0;
    seq = {1'b1, 8'h3C, 1'b0, 1'b1, 8'hA5, 1'b0};
    writeChar(9'h0A5);
    nextBit();
    check("R10 first start", txLine, seq[0]);
    writeChar(9'h03C);
    for (int i = 1; i < 20; i++) begin
      nextBit();
      check("R10 continuous bits", txLine, seq[i]);
    end
    nextBit();
    check("R10 idle after both", txIdle, 1'b1);

    // R8 priority: break, then preamble, then data
    txEnable = 1'b0;
    @(negedge clk);
    writeChar(9'h055);
    check("R9 write kept while disabled", bufEmpty, 1'b0);
    txEnable = 1'b1;
    pulseBreak();
    for (int i = 0; i < 11; i++) begin
      nextBit();
      check("R8 break first", txLine, 1'b0);
    end
    for (int i = 0; i < 10; i++) begin
      nextBit();
      check("R8 preamble second", txLine, 1'b1);
    end
    nextBit();
    check("R8 data start third", txLine, 1'b0);
    for (int b = 0; b < 8; b++) begin
      nextBit();
      check("R8 data bits", txLine, d_bit(9'h055, b));
    end
    nextBit();
    check("R8 stop", txLine, 1'b1);
    nextBit();
    check("R8 idle at end", txIdle, 1'b1);

    // R9 break ignored while disabled
    txEnable = 1'b0;
    @(negedge clk);
    pulseBreak();
    for (int i = 0; i < 3; i++) begin
      nextBit();
      check("R9 line high disabled", txLine, 1'b1);
      check("R9 break ignored", txIdle, 1'b1);
    end

    // R9 abort mid-frame
    txEnable = 1'b1;
    @(negedge clk);
    waitIdle();
    writeChar(9'h000);
    for (int i = 0; i < 3; i++) begin
      nextBit();
      check("R9 zeros sending", txLine, 1'b0);
    end
    txEnable = 1'b0;
    @(negedge clk);
    check("R9 line high after disable", txLine, 1'b1);
    check("R9 idle after abort", txIdle, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic d_bit(input logic [DATA_BITS-1:0] v, input int b);
    return v[b];
  endfunction
endmodule